// File: doc/BRIEF.md
# Byte-wide SPI master with two-stage clock prescaler

This block is a single-byte, full-duplex SPI master driven through four 16-bit registers on a simple synchronous bus. A configuration register selects the serial clock rate and the clock shape. The rate is the core clock divided by a linear factor times a power of two. A control register selects one of eight active-low chip selects, enables it, and holds a ready flag. Software clears the ready flag and writes a byte to the transmit register, which starts an eight-bit exchange. It then polls until the flag sets again and reads the captured byte from the receive register.

The clock-rate and shape settings are captured when a transfer starts, so a configuration write during a transfer only affects later transfers. Register reads return data one clock after the read strobe, and the read data holds its value between reads.

Top module: `spi_byte_master`

## Requirements
- R1: After a synchronous reset, all chip selects are high, SCK and MOSI are low, and every register reads back as zero.
- R2: The bus address selects the register: 0 is configuration, 1 is control, 2 is transmit, 3 is receive. Read data appears on the clock after the read strobe. In the configuration register, the linear divisor LIN sits in bits 3:0. The exponent EXP takes bit 0 from bit 4 and bits 2:1 from bits 7:6. The SCK idle level is bit 8 and the sample-edge select is bit 9. All other bits read as zero.
- R3: One SCK period lasts D = LIN × 2^EXP core clocks, and any D below 2 is raised to 2. Each period begins with ceil(D/2) clocks at the idle level, followed by floor(D/2) clocks at the active level.
- R4: SCK rests at the idle level whenever no transfer is running.
- R5: With the sample-edge select at 1, MISO is sampled on each leading edge (leaving idle) and MOSI changes on trailing edges. With the select at 0, MISO is sampled on trailing edges and MOSI changes on every leading edge after the first.
- R6: Bytes are shifted most-significant bit first. After the exchange, the receive register holds the eight sampled MISO bits.
- R7: The ready flag (control bit 0) sets one core clock after the eighth sampling edge. That edge comes 8·ceil(D/2)+7·floor(D/2) clocks after the accepting write clock when the sample-edge select is 1, and 8·D clocks after it when the select is 0.
- R8: A control write with bit 0 equal to 0 clears the ready flag. A control write with bit 0 equal to 1 leaves the flag unchanged and never sets it.
- R9: Control bits 4:2 hold a chip-select index and bit 1 is the enable. While the enable is 1, only chip select [index] is low. While it is 0, all chip selects are high.
- R10: A transmit-register write during a running transfer is ignored: the bits sent and the transmit read-back keep the original byte.
- R11: With LIN equal to 0, a transmit write starts nothing: SCK stays idle and the ready flag stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 8 | Active-low chip selects |

## Verification
The ready flag is due a fixed number of clocks after the accepting write, computed from D and the edge mode. The bench polls the control register on every clock and checks the first clock it reads 1 against that count plus the two clocks of read-path delay. SCK leading edges and sampled MOSI bits are checked by a monitor that looks at the pins half a clock after each rising edge. This gives the edge-to-edge spacing, which must be exactly D, and the bit order. Chip selects are checked two clocks after each control write, because both the register and the decoder are registered.

// File: rtl/spi_bm_pkg.sv
package spi_bm_pkg;
  localparam int REG_W   = 16;
  localparam int BYTE_W  = 8;
  localparam int LIN_W   = 4;
  localparam int EXP_W   = 3;
  localparam int DIV_W   = LIN_W + (1 << EXP_W) - 1;

  localparam int EXP_LO_POS = 4;
  localparam int EXP_HI_POS = 6;
  localparam int POL_POS    = 8;
  localparam int LEAD_POS   = 9;

  localparam int RDY_POS = 0;
  localparam int ACT_POS = 1;
  localparam int IDX_POS = 2;

  typedef enum logic [1:0] {
    A_CFG  = 2'd0,
    A_CTRL = 2'd1,
    A_TX   = 2'd2,
    A_RX   = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic             lead;
    logic             pol;
    logic [EXP_W-1:0] expo;
    logic [LIN_W-1:0] lin;
  } cfg_t;

  function automatic cfg_t cfg_unpack(input logic [REG_W-1:0] w);
    cfg_t c;
    c.lin  = w[LIN_W-1:0];
    c.expo = {w[EXP_HI_POS +: EXP_W-1], w[EXP_LO_POS]};
    c.pol  = w[POL_POS];
    c.lead = w[LEAD_POS];
    return c;
  endfunction

  function automatic logic [REG_W-1:0] cfg_pack(input cfg_t c);
    logic [REG_W-1:0] w;
    w = '0;
    w[LIN_W-1:0]               = c.lin;
    w[EXP_LO_POS]              = c.expo[0];
    w[EXP_HI_POS +: EXP_W-1]   = c.expo[EXP_W-1:1];
    w[POL_POS]                 = c.pol;
    w[LEAD_POS]                = c.lead;
    return w;
  endfunction
endpackage

// File: rtl/spi_bm_clkdiv.sv
module spi_bm_clkdiv #(
  parameter int LIN_W = 4,
  parameter int EXP_W = 3,
  parameter int DIV_W = 11
) (
  input  logic [LIN_W-1:0] lin,
  input  logic [EXP_W-1:0] expo,
  output logic [DIV_W-1:0] half_idle,
  output logic [DIV_W-1:0] half_act
);
  logic [DIV_W-1:0] full;
  logic [DIV_W-1:0] eff;

  always_comb begin
    full      = DIV_W'(lin) << expo;
    eff       = (full < DIV_W'(2)) ? DIV_W'(2) : full;
    half_act  = eff >> 1;
    half_idle = eff - half_act;
  end
endmodule

// File: rtl/spi_bm_engine.sv
module spi_bm_engine #(
  parameter int DIV_W  = 11,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              pol,
  input  logic              lead,
  input  logic [DIV_W-1:0]  half_idle,
  input  logic [DIV_W-1:0]  half_act,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              miso,
  output logic              busy,
  output logic              done,
  output logic              sck,
  output logic              mosi,
  output logic [BYTE_W-1:0] rx_byte
);
  localparam int EDGES = 2 * BYTE_W;
  localparam int K_W   = $clog2(EDGES);

  logic [K_W-1:0]    k;
  logic [DIV_W-1:0]  cnt, h_idle_s, h_act_s, cur_len;
  logic              pol_s, lead_s, fin, sck_q;
  logic [BYTE_W-1:0] sh_o, sh_i;
  logic              edge_now, samp_e, shift_e;
  logic [K_W-1:0]    last_k;

  always_comb begin
    cur_len  = k[0] ? h_act_s : h_idle_s;
    edge_now = (cnt == cur_len - 1'b1);
    samp_e   = lead_s ? ~k[0] : k[0];
    shift_e  = lead_s ? k[0] : (~k[0] && (k != '0));
    last_k   = lead_s ? K_W'(EDGES - 2) : K_W'(EDGES - 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      fin      <= 1'b0;
      k        <= '0;
      cnt      <= '0;
      sck_q    <= 1'b0;
      sh_o     <= '0;
      sh_i     <= '0;
      pol_s    <= 1'b0;
      lead_s   <= 1'b0;
      h_idle_s <= '0;
      h_act_s  <= '0;
    end else if (!busy) begin
      sck_q <= pol;
      if (start) begin
        busy     <= 1'b1;
        fin      <= 1'b0;
        k        <= '0;
        cnt      <= '0;
        sh_o     <= tx_byte;
        pol_s    <= pol;
        lead_s   <= lead;
        h_idle_s <= half_idle;
        h_act_s  <= half_act;
      end
    end else if (fin) begin
      busy  <= 1'b0;
      fin   <= 1'b0;
      sck_q <= pol_s;
    end else if (edge_now) begin
      cnt   <= '0;
      k     <= k + 1'b1;
      sck_q <= ~sck_q;
      if (samp_e) begin
        sh_i <= {sh_i[BYTE_W-2:0], miso};
        if (k == last_k) fin <= 1'b1;
      end
      if (shift_e) sh_o <= {sh_o[BYTE_W-2:0], 1'b0};
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign done    = busy & fin;
  assign sck     = sck_q;
  assign mosi    = sh_o[BYTE_W-1];
  assign rx_byte = sh_i;
endmodule

// File: rtl/spi_bm_regs.sv
module spi_bm_regs
  import spi_bm_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              busy,
  input  logic              done,
  input  logic [BYTE_W-1:0] rx_byte,
  output cfg_t              cfg,
  output logic [IDX_W-1:0]  cs_idx,
  output logic              cs_act,
  output logic              ready,
  output logic              start,
  output logic [BYTE_W-1:0] tx_byte
);
  cfg_t              cfg_q;
  logic [BYTE_W-1:0] tx_q, rx_q;
  logic [REG_W-1:0]  rd_mux;
  logic              wr_cfg, wr_ctrl;

  always_comb begin
    wr_cfg  = bus_wr && (bus_addr == A_CFG);
    wr_ctrl = bus_wr && (bus_addr == A_CTRL);
    start   = bus_wr && (bus_addr == A_TX) && !busy && (cfg_q.lin != '0);
    tx_byte = bus_wdata[BYTE_W-1:0];
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      A_CFG:  rd_mux = cfg_pack(cfg_q);
      A_CTRL: begin
        rd_mux[RDY_POS]         = ready;
        rd_mux[ACT_POS]         = cs_act;
        rd_mux[IDX_POS +: IDX_W] = cs_idx;
      end
      A_TX:    rd_mux[BYTE_W-1:0] = tx_q;
      default: rd_mux[BYTE_W-1:0] = rx_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q     <= '0;
      cs_idx    <= '0;
      cs_act    <= 1'b0;
      ready     <= 1'b0;
      tx_q      <= '0;
      rx_q      <= '0;
      bus_rdata <= '0;
    end else begin
      if (wr_cfg) cfg_q <= cfg_unpack(bus_wdata);
      if (wr_ctrl) begin
        cs_idx <= bus_wdata[IDX_POS +: IDX_W];
        cs_act <= bus_wdata[ACT_POS];
        if (!bus_wdata[RDY_POS]) ready <= 1'b0;
      end
      if (done) begin
        ready <= 1'b1;
        rx_q  <= rx_byte;
      end
      if (start) tx_q <= bus_wdata[BYTE_W-1:0];
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/spi_bm_csdec.sv
module spi_bm_csdec #(
  parameter int NCS   = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] idx,
  input  logic             act,
  output logic [NCS-1:0]   cs_n
);
  for (genvar i = 0; i < NCS; i++) begin : g_cs
    always_ff @(posedge clk) begin
      if (rst) cs_n[i] <= 1'b1;
      else     cs_n[i] <= ~(act && (idx == IDX_W'(i)));
    end
  end
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
  import spi_bm_pkg::*;
#(
  parameter int NCS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  output logic             sck,
  output logic             mosi,
  input  logic             miso,
  output logic [NCS-1:0]   cs_n
);
  localparam int IDX_W = (NCS > 1) ? $clog2(NCS) : 1;

  cfg_t              cfg;
  logic [IDX_W-1:0]  cs_idx;
  logic              cs_act, ready_flag, start, xfer_busy, done, spr_nz;
  logic [BYTE_W-1:0] tx_byte, rx_byte;
  logic [DIV_W-1:0]  half_idle, half_act;

  assign spr_nz = (cfg.lin != '0);

  spi_bm_regs #(.IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy(xfer_busy), .done(done), .rx_byte(rx_byte), .cfg(cfg),
    .cs_idx(cs_idx), .cs_act(cs_act), .ready(ready_flag),
    .start(start), .tx_byte(tx_byte)
  );

  spi_bm_clkdiv #(.LIN_W(LIN_W), .EXP_W(EXP_W), .DIV_W(DIV_W)) u_div (
    .lin(cfg.lin), .expo(cfg.expo),
    .half_idle(half_idle), .half_act(half_act)
  );

  spi_bm_engine #(.DIV_W(DIV_W), .BYTE_W(BYTE_W)) u_eng (
    .clk(clk), .rst(rst), .start(start), .pol(cfg.pol), .lead(cfg.lead),
    .half_idle(half_idle), .half_act(half_act), .tx_byte(tx_byte),
    .miso(miso), .busy(xfer_busy), .done(done), .sck(sck),
    .mosi(mosi), .rx_byte(rx_byte)
  );

  spi_bm_csdec #(.NCS(NCS), .IDX_W(IDX_W)) u_cs (
    .clk(clk), .rst(rst), .idx(cs_idx), .act(cs_act), .cs_n(cs_n)
  );
endmodule

// File: rtl/spi_bm_chk.sv
module spi_bm_chk #(
  parameter int NCS = 8
) (
  input logic           clk,
  input logic           rst,
  input logic [NCS-1:0] cs_n,
  input logic           sck,
  input logic           mosi,
  input logic           busy,
  input logic           ready,
  input logic           spr_nz
);
  // R9
  cs_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~cs_n));

  // R7
  ready_at_end_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> $fell(busy));

  // R11
  start_needs_lin_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(spr_nz));

  // R6
  mosi_on_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && $stable(sck)) |-> $stable(mosi));
endmodule

bind spi_byte_master spi_bm_chk #(.NCS(NCS)) u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .mosi(mosi),
  .busy(xfer_busy), .ready(ready_flag), .spr_nz(spr_nz)
);

// File: tb/spi_byte_master_tb.sv
`timescale 1ns/1ps
module spi_byte_master_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        sck, mosi;
  logic        miso = 1'b0;
  logic [7:0]  cs_n;

  int unsigned vectors = 0, miscompares = 0;
  int unsigned cyc = 0;
  logic        mon_en = 1'b0, m_pol = 1'b0, m_lead = 1'b0, sck_prev = 1'b0;
  logic [7:0]  slv = '0, got_mosi = '0;
  int unsigned nsamp = 0, nlead = 0, t_first = 0, t_last = 0;
  logic [2:0]  cur_idx = 3'd0;

  spi_byte_master u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] cfg_word(input int lin, input int ex, input bit pol, input bit lead);
    logic [15:0] w;
    w = 16'(lin & 15);
    w[4] = ex[0];
    w[7:6] = 2'(ex >> 1);
    w[8] = pol;
    w[9] = lead;
    return w;
  endfunction

  function automatic int div_of(input int lin, input int ex);
    int d;
    d = lin << ex;
    return (d < 2) ? 2 : d;
  endfunction

  function automatic int ready_delay(input int lin, input int ex, input bit lead);
    int d, ha, hi;
    d  = div_of(lin, ex);
    ha = d / 2;
    hi = d - ha;
    return lead ? (8 * hi + 7 * ha) : 8 * d;
  endfunction

  task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b0;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1; bus_wr = 1'b0;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  // bench-side peripheral and pin monitor
  always @(negedge clk) begin
    if (mon_en && (sck !== sck_prev)) begin
      if (sck != m_pol) begin
        if (nlead == 0) t_first = cyc;
        t_last = cyc;
        nlead++;
      end
      if ((m_lead && sck != m_pol) || (!m_lead && sck == m_pol)) begin
        got_mosi = {got_mosi[6:0], mosi};
        nsamp++;
      end else if (nsamp > 0) begin
        slv  = {slv[6:0], 1'b0};
        miso = slv[7];
      end
    end
    sck_prev = sck;
  end

  task automatic run_xfer(input int lin, input int ex, input bit pol, input bit lead,
                          input logic [7:0] tx, input logic [7:0] pat, input bit poke);
    int n;
    bit seen;
    logic [15:0] rd;
    m_pol = pol; m_lead = lead;
    bus_write(2'd0, cfg_word(lin, ex, pol, lead));
    bus_write(2'd1, {11'd0, cur_idx, 1'b1, 1'b0});
    repeat (2) @(negedge clk);
    nsamp = 0; nlead = 0; got_mosi = '0;
    slv = pat; miso = pat[7];
    mon_en = 1'b1;
    @(negedge clk);
    bus_addr = 2'd2; bus_wdata = {8'd0, tx}; bus_wr = 1'b1; bus_rd = 1'b0;
    n = 0; seen = 0;
    while (!seen && n < 20000) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      bus_wr = 1'b0;
      if (n >= 2 && bus_rdata[0]) seen = 1;
      else if (poke && n == 6) begin
        bus_addr = 2'd2; bus_wdata = {8'd0, ~tx}; bus_wr = 1'b1; bus_rd = 1'b0;
      end else begin
        bus_addr = 2'd1; bus_rd = 1'b1;
      end
    end
    bus_rd = 1'b0;
    repeat (3) @(negedge clk);
    mon_en = 1'b0;
    // R7 ready due delay+1 clocks after accept, read path adds two
    chk("R7 ready latency", 32'(n), 32'(ready_delay(lin, ex, lead) + 3));
    chk("R6 mosi byte msb first", {24'd0, got_mosi}, {24'd0, tx});
    chk("R5 sampling edge count", 32'(nsamp), 32'd8);
    chk("R3 leading edge count", 32'(nlead), 32'd8);
    chk("R3 sck period", 32'(t_last - t_first), 32'(7 * div_of(lin, ex)));
    chk("R4 sck idle level", {31'd0, sck}, {31'd0, pol});
    bus_read(2'd3, rd);
    chk("R6 receive register", {16'd0, rd}, {24'd0, pat});
    if (poke) begin
      bus_read(2'd2, rd);
      chk("R10 transmit readback after ignored write", {16'd0, rd}, {24'd0, tx});
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    vectors++;
    miscompares++;
    $display("FAIL R7 watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] rd;
    int unsigned seed;
    seed = $urandom(32'd2024);
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 cs_n after reset", {24'd0, cs_n}, 32'hFF);
    chk("R1 sck after reset", {31'd0, sck}, 32'd0);
    chk("R1 mosi after reset", {31'd0, mosi}, 32'd0);
    for (int a = 0; a < 4; a++) begin
      bus_read(2'(a), rd);
      chk("R1 register reset value", {16'd0, rd}, 32'd0);
    end

    // R2 configuration field layout
    bus_write(2'd0, 16'hFFFF);
    bus_read(2'd0, rd);
    chk("R2 config readback mask", {16'd0, rd}, 32'h03DF);
    repeat (2) @(negedge clk);
    chk("R4 sck follows idle level", {31'd0, sck}, 32'd1);

    // R9 chip select steering
    for (int i = 0; i < 8; i++) begin
      bus_write(2'd1, {11'd0, 3'(i), 1'b1, 1'b0});
      @(negedge clk);
      chk("R9 one chip select low", {24'd0, cs_n}, {24'd0, ~(8'd1 << i)});
    end
    bus_write(2'd1, {11'd0, 3'd5, 1'b0, 1'b0});
    @(negedge clk);
    chk("R9 release all selects", {24'd0, cs_n}, 32'hFF);
    bus_read(2'd1, rd);
    chk("R2 control readback", {16'd0, rd}, 32'h14);
    cur_idx = 3'd3;

    // directed edge cases
    run_xfer(1, 0, 1'b0, 1'b1, 8'hA5, 8'h3C, 1'b0);
    run_xfer(1, 0, 1'b1, 1'b0, 8'h5A, 8'hC3, 1'b0);
    run_xfer(3, 0, 1'b0, 1'b0, 8'h81, 8'h7E, 1'b0);
    run_xfer(2, 1, 1'b1, 1'b1, 8'h01, 8'h80, 1'b0);
    run_xfer(1, 7, 1'b0, 1'b1, 8'hF0, 8'h0F, 1'b0);
    run_xfer(15, 7, 1'b1, 1'b0, 8'h96, 8'h69, 1'b0);
    // R10 write during transfer
    run_xfer(5, 2, 1'b0, 1'b1, 8'hC7, 8'h2B, 1'b1);
    run_xfer(7, 1, 1'b1, 1'b0, 8'h3E, 8'hD4, 1'b1);

    // R8 ready flag write rules
    bus_write(2'd1, {11'd0, cur_idx, 1'b1, 1'b1});
    bus_read(2'd1, rd);
    chk("R8 write one keeps ready set", {31'd0, rd[0]}, 32'd1);
    bus_write(2'd1, {11'd0, cur_idx, 1'b1, 1'b0});
    bus_read(2'd1, rd);
    chk("R8 write zero clears ready", {31'd0, rd[0]}, 32'd0);
    bus_write(2'd1, {11'd0, cur_idx, 1'b1, 1'b1});
    bus_read(2'd1, rd);
    chk("R8 write one does not set ready", {31'd0, rd[0]}, 32'd0);

    // R11 zero linear divisor blocks start
    m_pol = 1'b1; m_lead = 1'b0;
    bus_write(2'd0, cfg_word(0, 3, 1'b1, 1'b0));
    repeat (2) @(negedge clk);
    nlead = 0; nsamp = 0; mon_en = 1'b1;
    bus_write(2'd2, 16'h00AA);
    repeat (60) @(negedge clk);
    mon_en = 1'b0;
    chk("R11 no sck activity", 32'(nlead + nsamp), 32'd0);
    chk("R11 sck stays idle", {31'd0, sck}, 32'd1);
    bus_read(2'd1, rd);
    chk("R11 ready stays clear", {31'd0, rd[0]}, 32'd0);

    // constrained random transfers
    for (int t = 0; t < 24; t++) begin
      int lin, ex;
      lin = 1 + int'($urandom % 15);
      ex  = int'($urandom % 4);
      cur_idx = 3'($urandom % 8);
      run_xfer(lin, ex, 1'($urandom % 2), 1'($urandom % 2),
               8'($urandom), 8'($urandom), 1'(t % 5 == 0));
      chk("R9 selected chip during transfers", {24'd0, cs_n}, {24'd0, ~(8'd1 << cur_idx)});
    end

    summary();
    $finish;
  end
endmodule